// File: doc/BRIEF.md
# Buck Regulator Protection Supervisor

This block watches a set of per-cycle comparator flags from a step-down converter and decides when switching must stop. Over-voltage, under-voltage and pulse-by-pulse current-limit flags each pass through a consecutive-cycle filter of their own. A high-side short or a die over-temperature event acts at once. The first qualified fault sets a single fault latch. The latch removes the switching permit, records which sources caused it and starts a hysteretic discharge of the output through the low-side switch.

While it is latched, the block asks the enable pin to be drained. Once the enable pin has been seen below its low threshold, the block waits for an explicit restart request, which comes from a re-enable or a bias cycle. It accepts that request only if no over-temperature condition remains. The under-voltage filter runs only after the soft-start sequencer raises its arm input. Current limit, short and over-temperature protection are active at all times.

The controller is a three-state machine:
- `ST_RUN`: switching is permitted.
- `ST_TRIP`: the fault is latched and the enable drain is requested.
- `ST_REARM`: the fault is latched, the enable pin has been drained, and the block waits for a restart.

The transitions are:
- **trip** (`ST_RUN` to `ST_TRIP`): any qualified fault.
- **drained** (`ST_TRIP` to `ST_REARM`): `en_low` is seen.
- **rearm** (`ST_REARM` to `ST_RUN`): `restart_req` arrives and no over-temperature condition remains.

Top module: `buck_guard`

## Requirements
- R1: With the default `OV_CYCLES` of 2, `fault_latched` rises after the second consecutive clock edge at which `ov_cmp` is high. A single high cycle does not latch.
- R2: With the default `UV_CYCLES` of 16, `uv_cmp` latches the fault after 16 consecutive high edges, but only while `fault_arm` is high. With `fault_arm` low, `uv_cmp` never latches the fault.
- R3: With the default `OC_CYCLES` of 16, `oc_trip` latches the fault after 16 consecutive high edges, whatever the value of `fault_arm`.
- R4: A cycle in which a filtered flag is low clears that flag's count to zero. A later run needs the full count again.
- R5: `hs_short` high at one edge while running latches the fault at that edge, with `fault_arm` low.
- R6: `ot_hot` high at one edge while running latches the fault at that edge. After that, `restart_req` is refused until `ot_cool` has been seen, and refused while `ot_hot` is high.
- R7: While latched, `sw_enable` is 0. `ls_dis` is 1 from the trip edge, clears at an edge where `fb_low` is high, and sets again at an edge where `fb_high` is high with `fb_low` low. Otherwise it holds. `ls_dis` is 0 while running.
- R8: `en_dis_req` is 1 from the trip edge until an edge with `en_low` high. `restart_req` is ignored until that has happened.
- R9: `fault_cause` captures, at the trip edge, one bit per source that qualified: bit0 over-voltage, bit1 under-voltage, bit2 current limit, bit3 over-temperature, bit4 high-side short. It holds that value while latched and is 0 while running.
- R10: After reset, the block is running: `sw_enable`=1, `fault_latched`=0, `en_dis_req`=0, `ls_dis`=0, `fault_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | switching-cycle clock |
| rst_n | input | 1 | active-low reset (bias-up) |
| fault_arm | input | 1 | soft-start reached the arming level |
| ov_cmp | input | 1 | feedback above the over-voltage threshold |
| uv_cmp | input | 1 | feedback below the under-voltage threshold |
| oc_trip | input | 1 | this cycle hit the pulse-by-pulse current limit |
| ot_hot | input | 1 | die above the over-temperature set point |
| ot_cool | input | 1 | die below the over-temperature release point |
| hs_short | input | 1 | switch node high while the low-side switch is fully on |
| fb_low | input | 1 | feedback below the discharge-off level |
| fb_high | input | 1 | feedback above the discharge-on level |
| en_low | input | 1 | enable pin below its low threshold |
| restart_req | input | 1 | re-enable or bias-cycle restart request |
| sw_enable | output | 1 | switching permitted |
| fault_latched | output | 1 | fault latch state |
| en_dis_req | output | 1 | request to drain the enable pin |
| ls_dis | output | 1 | turn the low-side switch on to discharge the output |
| fault_cause | output | 5 | sources that set the latch |

## Verification
Each filtered flag is driven with unbroken runs of every length from zero to a few cycles past its limit. This separates an off-by-one in the count from a correct trip at exactly the limit edge. The under-voltage runs are repeated with the arm input low to show that the gate blocks the check, and the current-limit runs with the arm input low to show that no gate applies there. A run with one cycle missing just before the limit tells a clearing counter from a saturating or merely holding one. Scripted sequences on `fb_low`/`fb_high`, `en_low`, `ot_cool` and `restart_req` walk the discharge hysteresis and each restart gate in turn. Each sequence includes an early restart that must be refused.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_TRIP  = 2'd1,
        ST_REARM = 2'd2
    } guard_state_t;

    localparam int BG_NSRC   = 5;
    localparam int SRC_OV    = 0;
    localparam int SRC_UV    = 1;
    localparam int SRC_OC    = 2;
    localparam int SRC_OT    = 3;
    localparam int SRC_HS    = 4;
    localparam int BG_NFILT  = 3;

endpackage

// File: rtl/bg_debounce.sv
module bg_debounce #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    output logic fire
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !hit) begin
            cnt <= '0;   // r4_ a missing cycle restarts the count
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fire = hit && !clr && (cnt == TOP);

endmodule

// File: rtl/bg_discharge.sv
module bg_discharge (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic fb_low,
    input  logic fb_high,
    output logic on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on <= 1'b0;
        end else if (start) begin
            on <= 1'b1;
        end else if (!active) begin
            on <= 1'b0;
        end else if (fb_low) begin
            on <= 1'b0;
        end else if (fb_high) begin
            on <= 1'b1;
        end
    end
endmodule

// File: rtl/buck_guard.sv
module buck_guard
    import buck_guard_pkg::*;
#(
    parameter int OV_CYCLES = 2,
    parameter int UV_CYCLES = 16,
    parameter int OC_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_arm,
    input  logic               ov_cmp,
    input  logic               uv_cmp,
    input  logic               oc_trip,
    input  logic               ot_hot,
    input  logic               ot_cool,
    input  logic               hs_short,
    input  logic               fb_low,
    input  logic               fb_high,
    input  logic               en_low,
    input  logic               restart_req,
    output logic               sw_enable,
    output logic               fault_latched,
    output logic               en_dis_req,
    output logic               ls_dis,
    output logic [BG_NSRC-1:0] fault_cause
);
    guard_state_t state, state_nxt;

    logic                run;
    logic                trip;
    logic                go_run;
    logic                ot_flag;
    logic [BG_NFILT-1:0] db_hit, db_clr, db_fire;
    logic [BG_NSRC-1:0]  hits;

    assign run = (state == ST_RUN);

    assign db_hit = {oc_trip, uv_cmp, ov_cmp};
    assign db_clr = {~run, ~run | ~fault_arm, ~run};   // r2_ under-voltage gated by arm

    for (genvar g = 0; g < BG_NFILT; g++) begin : g_filt
        localparam int LIM = (g == SRC_OV) ? OV_CYCLES :
                             (g == SRC_UV) ? UV_CYCLES : OC_CYCLES;
        bg_debounce #(.LIMIT(LIM)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (db_clr[g]),
            .hit   (db_hit[g]),
            .fire  (db_fire[g])
        );
    end

    assign hits = {hs_short & run, ot_hot & run, db_fire};
    assign trip = run && (|hits);
    assign go_run = (state == ST_REARM) && restart_req && !ot_flag && !ot_hot;

    // over-temperature memory: set hot, released only by cool (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ot_flag <= 1'b0;
        else if (ot_hot)  ot_flag <= 1'b1;
        else if (ot_cool) ot_flag <= 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (trip)   state_nxt = ST_TRIP;
            ST_TRIP:  if (en_low) state_nxt = ST_REARM;
            ST_REARM: if (go_run) state_nxt = ST_RUN;
            default:              state_nxt = ST_RUN;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sw_enable     = 1'b0;
        fault_latched = 1'b1;
        en_dis_req    = 1'b0;
        unique case (state)
            ST_RUN: begin
                sw_enable     = 1'b1;
                fault_latched = 1'b0;
            end
            ST_TRIP:  en_dis_req = 1'b1;
            ST_REARM: en_dis_req = 1'b0;
            default: begin
                sw_enable     = 1'b0;
                fault_latched = 1'b1;
            end
        endcase
    end

    // cause capture (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fault_cause <= '0;
        else if (trip)   fault_cause <= hits;
        else if (go_run) fault_cause <= '0;
    end

    bg_discharge u_dis (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (trip),
        .active  (state_nxt != ST_RUN),
        .fb_low  (fb_low),
        .fb_high (fb_high),
        .on      (ls_dis)
    );

endmodule

// File: rtl/buck_guard_chk.sv
module buck_guard_chk
    import buck_guard_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fault_arm,
    input logic               ov_cmp,
    input logic               hs_short,
    input logic               ot_hot,
    input logic               fb_low,
    input logic               restart_req,
    input logic               sw_enable,
    input logic               fault_latched,
    input logic               en_dis_req,
    input logic               ls_dis,
    input logic [BG_NSRC-1:0] fault_cause
);
    a_r1_ov_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_enable && ov_cmp && $past(ov_cmp) && $past(sw_enable)) |=> fault_latched);

    a_r5_short_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_enable && hs_short) |=> (fault_latched && fault_cause[SRC_HS]));

    a_r6_hot_blocks_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && ot_hot) |=> fault_latched);

    a_r7_no_discharge_running: assert property (@(posedge clk) disable iff (!rst_n)
        sw_enable |-> !ls_dis);

    a_r7_low_stops_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && fb_low) |=> !ls_dis);

    a_r7_latched_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> !sw_enable);

    a_r8_drain_only_latched: assert property (@(posedge clk) disable iff (!rst_n)
        en_dis_req |-> fault_latched);

    a_r8_no_restart_draining: assert property (@(posedge clk) disable iff (!rst_n)
        (en_dis_req && restart_req) |=> fault_latched);

    a_r9_cause_clear_running: assert property (@(posedge clk) disable iff (!rst_n)
        sw_enable |-> (fault_cause == '0));

    a_r9_cause_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && $past(fault_latched)) |-> $stable(fault_cause));

endmodule

bind buck_guard buck_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_arm     (fault_arm),
    .ov_cmp        (ov_cmp),
    .hs_short      (hs_short),
    .ot_hot        (ot_hot),
    .fb_low        (fb_low),
    .restart_req   (restart_req),
    .sw_enable     (sw_enable),
    .fault_latched (fault_latched),
    .en_dis_req    (en_dis_req),
    .ls_dis        (ls_dis),
    .fault_cause   (fault_cause)
);

// File: tb/buck_guard_tb.sv
module buck_guard_tb;
    localparam int OVN = 2;
    localparam int UVN = 16;
    localparam int OCN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_arm = 0, ov_cmp = 0, uv_cmp = 0, oc_trip = 0, ot_hot = 0, ot_cool = 0;
    logic hs_short = 0, fb_low = 0, fb_high = 0, en_low = 0, restart_req = 0;
    logic sw_enable, fault_latched, en_dis_req, ls_dis;
    logic [4:0] fault_cause;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    buck_guard #(.OV_CYCLES(OVN), .UV_CYCLES(UVN), .OC_CYCLES(OCN)) u_dut (
        .clk(clk), .rst_n(rst_n), .fault_arm(fault_arm), .ov_cmp(ov_cmp),
        .uv_cmp(uv_cmp), .oc_trip(oc_trip), .ot_hot(ot_hot), .ot_cool(ot_cool),
        .hs_short(hs_short), .fb_low(fb_low), .fb_high(fb_high), .en_low(en_low),
        .restart_req(restart_req), .sw_enable(sw_enable),
        .fault_latched(fault_latched), .en_dis_req(en_dis_req), .ls_dis(ls_dis),
        .fault_cause(fault_cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_src(input int which, input logic v);
        case (which)
            0: ov_cmp  = v;
            1: uv_cmp  = v;
            default: oc_trip = v;
        endcase
    endtask

    task automatic recover();
        ov_cmp = 0; uv_cmp = 0; oc_trip = 0; hs_short = 0; ot_hot = 0;
        en_low = 1; step(); en_low = 0;
        chk("R8 drain released", int'(en_dis_req), 0);
        restart_req = 1; step(); restart_req = 0;
        chk("R8 restart resumes", int'(sw_enable), 1);
        chk("R9 cause cleared", int'(fault_cause), 0);
        chk("R7 discharge off running", int'(ls_dis), 0);
    endtask

    // drive one filtered source for len cycles; trip expected at lim (0: never)
    task automatic run_len(input int which, input int len, input logic arm, input int lim,
                           input string req);
        bit tripped = 0;
        fault_arm = arm;
        for (int k = 1; k <= len; k++) begin
            drive_src(which, 1'b1);
            step();
            chk(req, int'(fault_latched), (lim != 0 && k >= lim) ? 1 : 0);
            if (lim != 0 && k >= lim) tripped = 1;
        end
        drive_src(which, 1'b0);
        if (tripped) begin
            chk("R9 cause bit", int'(fault_cause), 1 << which);
            chk("R8 drain req", int'(en_dis_req), 1);
            recover();
        end else begin
            step();
            chk(req, int'(fault_latched), 0);
        end
        fault_arm = 0;
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset sw_enable", int'(sw_enable), 1);
        chk("R10 reset latched", int'(fault_latched), 0);
        chk("R10 reset drain", int'(en_dis_req), 0);
        chk("R10 reset discharge", int'(ls_dis), 0);
        chk("R10 reset cause", int'(fault_cause), 0);

        // R1 over-voltage run lengths
        for (int L = 0; L <= OVN + 2; L++) run_len(0, L, 1'b0, OVN, "R1 ov run");
        // R2 under-voltage, armed and unarmed
        for (int L = 0; L <= UVN + 2; L++) run_len(1, L, 1'b1, UVN, "R2 uv armed");
        run_len(1, UVN + 4, 1'b0, 0, "R2 uv unarmed");
        // R3 current limit, arm ignored
        for (int L = OCN - 2; L <= OCN + 1; L++) run_len(2, L, 1'b0, OCN, "R3 oc unarmed");
        run_len(2, OCN, 1'b1, OCN, "R3 oc armed");

        // R4 broken run restarts the count
        for (int k = 0; k < OCN - 1; k++) begin oc_trip = 1; step(); end
        oc_trip = 0; step();
        chk("R4 gap no trip", int'(fault_latched), 0);
        for (int k = 0; k < OCN - 1; k++) begin oc_trip = 1; step(); end
        chk("R4 short rerun no trip", int'(fault_latched), 0);
        step();
        chk("R4 full rerun trips", int'(fault_latched), 1);
        oc_trip = 0;
        recover();

        // R5 short, and R7 discharge hysteresis
        hs_short = 1; step(); hs_short = 0;
        chk("R5 short latched", int'(fault_latched), 1);
        chk("R5 short cause", int'(fault_cause), 16);
        chk("R7 switching off", int'(sw_enable), 0);
        chk("R7 discharge on at trip", int'(ls_dis), 1);
        fb_low = 1; step(); fb_low = 0;
        chk("R7 low stops discharge", int'(ls_dis), 0);
        step();
        chk("R7 holds off between", int'(ls_dis), 0);
        fb_high = 1; step();
        chk("R7 high restarts discharge", int'(ls_dis), 1);
        fb_high = 0; step();
        chk("R7 holds on between", int'(ls_dis), 1);
        fb_low = 1; fb_high = 1; step(); fb_low = 0; fb_high = 0;
        chk("R7 low wins", int'(ls_dis), 0);
        restart_req = 1; step(); restart_req = 0;
        chk("R8 restart before drain refused", int'(fault_latched), 1);
        chk("R8 drain still requested", int'(en_dis_req), 1);
        recover();

        // R6 over-temperature
        ot_hot = 1; step(); ot_hot = 0;
        chk("R6 hot latched", int'(fault_latched), 1);
        chk("R6 hot cause", int'(fault_cause), 8);
        en_low = 1; step(); en_low = 0;
        restart_req = 1; step(); restart_req = 0;
        chk("R6 restart refused while hot", int'(fault_latched), 1);
        chk("R9 cause held", int'(fault_cause), 8);
        ot_cool = 1; step(); ot_cool = 0;
        restart_req = 1; step(); restart_req = 0;
        chk("R6 restart after cool", int'(sw_enable), 1);
        chk("R9 cause cleared on restart", int'(fault_cause), 0);

        // R9 simultaneous sources
        ov_cmp = 1; step();
        hs_short = 1; step(); ov_cmp = 0; hs_short = 0;
        chk("R9 both causes", int'(fault_cause), 17);
        recover();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule